// File: doc/BRIEF.md
# Instruction Line-Fill Requester

This block sits between an instruction cache and a 64-bit read bus. When the cache reports a miss, the block raises a line read request carrying the line-aligned 30-bit word address. It then waits for the bus to accept the address. After acceptance it gathers four 64-bit data beats into a four-slot fill buffer. The slot for each beat comes from the word-address tag returned with it, so beats that arrive out of order still land in the right place. Once all four beats are in, the complete eight-word line is presented to the cache for one cycle through a write strobe.

The processor side may run faster than the bus by an integer ratio. A `bus_en` strobe marks the processor cycles that fall on a bus-clock edge. Bus handshakes (address accept and data beats) are sampled only in those cycles. The core can withdraw an outstanding request when control flow changes. If the withdrawal coincides with the address accept, the accept is discarded and no data is awaited.

Control is a four-state machine. `IDLE` moves to `REQ` when a miss is reported. `REQ` moves back to `IDLE` on abort, or to `FILL` on an accepted address. `FILL` moves to `WRITE` when the fourth beat arrives. `WRITE` returns to `IDLE` after one cycle.

Top module: `ifetch_line_filler`

## Requirements
- R1: After reset, `req_o`, `busy_o` and `line_we_o` are low.
- R2: A `miss_i` seen in IDLE puts `req_o` and `busy_o` high on the next cycle. `addr_o` then equals `miss_addr_i` with its three low bits cleared.
- R3: `req_o` stays high until an address accept or an abort. It falls on the cycle after `addr_ack_i` is sampled in a cycle where `bus_en` is high. An accept in a cycle with `bus_en` low is ignored, and an accept may come in the very first cycle of the request.
- R4: `abort_i` while requesting, including in the same cycle as an accepted address, clears `req_o` and `busy_o` on the next cycle. No line write follows, even if data beats are later signalled.
- R5: While filling, a beat is taken only when `rd_ack_i` and `bus_en` are both high. It goes to slot `rd_tag_i[2:1]`, so tags 0, 2, 4 and 6 select slots 0 to 3 in any arrival order.
- R6: On the cycle after the fourth beat, `line_we_o` is high for exactly one cycle. `line_addr_o` then holds the requested line address, and slot k sits in `line_data_o[255-64k -: 64]`. The word with even index is in the upper half of its slot.
- R7: `busy_o` is high from the first request cycle until the line write cycle ends or an abort takes effect.
- R8: An abort raised after the address was accepted has no effect, and the line is still written.
- R9: A miss reported while busy is ignored, and `line_addr_o` keeps the address of the line in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | High in processor cycles that fall on a bus-clock edge |
| miss_i | input | 1 | Cache miss report |
| miss_addr_i | input | 30 | Word address of the missing instruction |
| abort_i | input | 1 | Control-flow change, withdraw request |
| req_o | output | 1 | Line read request |
| addr_o | output | 30 | Line-aligned word address |
| addr_ack_i | input | 1 | Bus address accept |
| rd_ack_i | input | 1 | Data beat valid |
| rd_tag_i | input | 3 | Word address of the beat's first word |
| rd_data_i | input | 64 | Data beat |
| busy_o | output | 1 | Line fill in progress |
| line_we_o | output | 1 | One-cycle line write strobe to the cache |
| line_addr_o | output | 30 | Line address for the cache write |
| line_data_o | output | 256 | Assembled eight-word line |

## Verification
A state that is off by one shows at the ports within a cycle or two. A request that lingers after an accept, or drops during a non-boundary cycle, is visible on `req_o` on the very next cycle. A beat counter that miscounts fires `line_we_o` early or never, and this shows on the cycle after the fourth beat. Wrong slot steering changes which 64-bit field of `line_data_o` holds a given beat. Out-of-order tags and a 3:1 ratio expose this at the single write strobe.

// File: rtl/lfill_pkg.sv
package lfill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_FILL  = 2'd2,
        ST_WRITE = 2'd3
    } lfill_state_t;
endpackage

// File: rtl/lfill_ctrl.sv
module lfill_ctrl
    import lfill_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int BEATS  = 4,
    parameter int OFS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              miss_i,
    input  logic [ADDR_W-1:0] miss_addr_i,
    input  logic              abort_i,
    input  logic              addr_ack_i,
    input  logic              rd_ack_i,
    output logic              req_o,
    output logic              busy_o,
    output logic              line_we_o,
    output logic              beat_we_o,
    output logic [ADDR_W-1:0] line_addr_o
);
    localparam int CNT_W = $clog2(BEATS);

    lfill_state_t state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              take_beat;

    assign take_beat = (state_q == ST_FILL) && bus_en && rd_ack_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_i) state_d = ST_REQ;
            ST_REQ: begin
                if (abort_i)                  state_d = ST_IDLE;
                else if (bus_en && addr_ack_i) state_d = ST_FILL;
            end
            ST_FILL:  if (take_beat && cnt_q == CNT_W'(BEATS - 1)) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && miss_i) begin
                addr_q <= {miss_addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                cnt_q  <= '0;
            end else if (take_beat) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        req_o     = 1'b0;
        busy_o    = 1'b1;
        line_we_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o    = 1'b0;
            ST_REQ:   req_o     = 1'b1;
            ST_FILL:  ;
            ST_WRITE: line_we_o = 1'b1;
            default:  busy_o    = 1'b0;
        endcase
    end

    assign beat_we_o   = take_beat;
    assign line_addr_o = addr_q;
endmodule

// File: rtl/lfill_slots.sv
module lfill_slots #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    parameter int TAG_W  = 3
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [TAG_W-1:0]        tag,
    input  logic [BEAT_W-1:0]       data,
    output logic [BEATS*BEAT_W-1:0] line
);
    localparam int IDX_W  = $clog2(BEATS);
    localparam int LINE_W = BEATS * BEAT_W;

    logic [IDX_W-1:0] idx;
    assign idx = tag[TAG_W-1 -: IDX_W];

    for (genvar k = 0; k < BEATS; k++) begin : g_slot
        logic [BEAT_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (we && idx == IDX_W'(k)) slot_q <= data;
        end
        assign line[LINE_W-1-k*BEAT_W -: BEAT_W] = slot_q;
    end
endmodule

// File: rtl/ifetch_line_filler.sv
module ifetch_line_filler #(
    parameter int ADDR_W = 30,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    parameter int TAG_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    miss_i,
    input  logic [ADDR_W-1:0]       miss_addr_i,
    input  logic                    abort_i,
    output logic                    req_o,
    output logic [ADDR_W-1:0]       addr_o,
    input  logic                    addr_ack_i,
    input  logic                    rd_ack_i,
    input  logic [TAG_W-1:0]        rd_tag_i,
    input  logic [BEAT_W-1:0]       rd_data_i,
    output logic                    busy_o,
    output logic                    line_we_o,
    output logic [ADDR_W-1:0]       line_addr_o,
    output logic [BEATS*BEAT_W-1:0] line_data_o
);
    localparam int WORD_W = 32;
    localparam int OFS_W  = $clog2(BEATS * BEAT_W / WORD_W);

    logic beat_we;

    lfill_ctrl #(.ADDR_W(ADDR_W), .BEATS(BEATS), .OFS_W(OFS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en),
        .miss_i(miss_i), .miss_addr_i(miss_addr_i), .abort_i(abort_i),
        .addr_ack_i(addr_ack_i), .rd_ack_i(rd_ack_i),
        .req_o(req_o), .busy_o(busy_o), .line_we_o(line_we_o),
        .beat_we_o(beat_we), .line_addr_o(line_addr_o)
    );

    lfill_slots #(.BEAT_W(BEAT_W), .BEATS(BEATS), .TAG_W(TAG_W)) u_slots (
        .clk(clk), .we(beat_we), .tag(rd_tag_i), .data(rd_data_i),
        .line(line_data_o)
    );

    assign addr_o = line_addr_o;
endmodule

// File: rtl/ifetch_line_filler_chk.sv
module ifetch_line_filler_chk #(
    parameter int ADDR_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              miss_i,
    input logic              abort_i,
    input logic              addr_ack_i,
    input logic              req_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              line_we_o
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !req_o && !busy_o && !line_we_o);
    // R2
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n) req_o |-> addr_o[2:0] == 3'b000);
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n) !busy_o && miss_i |=> req_o && busy_o);
    // R3
    a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && bus_en && addr_ack_i |=> !req_o);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !abort_i && !(bus_en && addr_ack_i) |=> req_o && $stable(addr_o));
    // R4
    a_r4_abort_idle: assert property (@(posedge clk) disable iff (!rst_n) req_o && abort_i |=> !busy_o);
    // R6
    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n) line_we_o |=> !line_we_o && !busy_o);
    // R7
    a_r7_busy_cover: assert property (@(posedge clk) disable iff (!rst_n) (req_o || line_we_o) |-> busy_o);
endmodule

bind ifetch_line_filler ifetch_line_filler_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .miss_i(miss_i), .abort_i(abort_i),
    .addr_ack_i(addr_ack_i), .req_o(req_o), .addr_o(addr_o), .busy_o(busy_o),
    .line_we_o(line_we_o)
);

// File: tb/ifetch_line_filler_test.sv
module ifetch_line_filler_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss = 1'b0, abort = 1'b0, aack = 1'b0, rack = 1'b0;
    logic [29:0] maddr = '0;
    logic [2:0]  tag = '0;
    logic [63:0] rdata = '0;
    logic req, busy, lwe;
    logic [29:0] addr, laddr;
    logic [255:0] ldata;
    logic bus_en;
    int ratio = 1;
    int dcnt = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) dcnt <= (dcnt >= ratio - 1) ? 0 : dcnt + 1;
    assign bus_en = (dcnt == 0);

    ifetch_line_filler uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .miss_i(miss), .miss_addr_i(maddr),
        .abort_i(abort), .req_o(req), .addr_o(addr), .addr_ack_i(aack),
        .rd_ack_i(rack), .rd_tag_i(tag), .rd_data_i(rdata), .busy_o(busy),
        .line_we_o(lwe), .line_addr_o(laddr), .line_data_o(ldata)
    );

    task automatic chk(string r, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic tick_bus();
        bit seen;
        do begin
            seen = bus_en;
            @(negedge clk);
        end while (!seen);
    endtask

    task automatic start_req(logic [29:0] a);
        maddr = a; miss = 1'b1;
        @(negedge clk);
        miss = 1'b0;
        chk("R2 req", req, 1); chk("R7 busy", busy, 1);
        chk("R2 addr", addr, {a[29:3], 3'b000});
    endtask

    task automatic accept();
        aack = 1'b1; tick_bus(); aack = 1'b0;
        chk("R3 req drop", req, 0);
    endtask

    task automatic beats(input logic [2:0] tg [4], input logic [63:0] dv [4],
                         output logic [255:0] exp);
        exp = '0;
        for (int i = 0; i < 4; i++) begin
            rack = 1'b1; tag = tg[i]; rdata = dv[i];
            tick_bus();
            rack = 1'b0;
            exp[255 - 64*int'(tg[i][2:1]) -: 64] = dv[i];
            if (i < 3) chk("R7 busy mid", busy, 1);
        end
    endtask

    task automatic t_reset();
        chk("R1 req", req, 0); chk("R1 busy", busy, 0); chk("R1 we", lwe, 0);
    endtask

    task automatic t_in_order();
        logic [2:0] tg [4] = '{3'd0, 3'd2, 3'd4, 3'd6};
        logic [63:0] dv [4] = '{64'h00000000_11111111, 64'h22222222_33333333,
                                64'h44444444_55555555, 64'h66666666_77777777};
        logic [255:0] exp;
        start_req(30'h12345677);
        accept();
        beats(tg, dv, exp);
        chk("R6 we", lwe, 1); chk("R6 addr", laddr, 30'h12345670); chk("R6 data", ldata, exp);
        @(negedge clk);
        chk("R6 one pulse", lwe, 0); chk("R7 busy end", busy, 0);
    endtask

    task automatic t_out_of_order();
        logic [2:0] tg [4] = '{3'd6, 3'd0, 3'd4, 3'd2};
        logic [63:0] dv [4] = '{64'hA6A6A6A6_B7B7B7B7, 64'hA0A0A0A0_B1B1B1B1,
                                64'hA4A4A4A4_B5B5B5B5, 64'hA2A2A2A2_B3B3B3B3};
        logic [255:0] exp;
        start_req(30'h00000F0B);
        repeat (2) @(negedge clk);
        chk("R3 hold", req, 1);
        accept();
        repeat (3) @(negedge clk);
        chk("R5 wait", lwe, 0);
        beats(tg, dv, exp);
        chk("R5 slot steer", ldata, exp);
        chk("R6 addr ooo", laddr, 30'h00000F08);
        @(negedge clk);
    endtask

    task automatic t_abort_same();
        start_req(30'h0000AAA5);
        aack = 1'b1; abort = 1'b1;
        @(negedge clk);
        aack = 1'b0; abort = 1'b0;
        chk("R4 req", req, 0); chk("R4 busy", busy, 0);
        for (int i = 0; i < 4; i++) begin
            rack = 1'b1; tag = 3'(2*i); rdata = 64'hDEAD;
            @(negedge clk);
            chk("R4 no write", lwe, 0);
        end
        rack = 1'b0;
        @(negedge clk);
        chk("R4 still idle", busy, 0);
    endtask

    task automatic t_abort_then_restart();
        logic [2:0] tg [4] = '{3'd0, 3'd2, 3'd4, 3'd6};
        logic [63:0] dv [4] = '{64'h1, 64'h2, 64'h3, 64'h4};
        logic [255:0] exp;
        start_req(30'h00001000);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R4 abort pending", busy, 0);
        start_req(30'h00077779);
        accept();
        beats(tg, dv, exp);
        chk("R6 restart addr", laddr, 30'h00077778);
        chk("R6 restart data", ldata, exp);
        @(negedge clk);
    endtask

    task automatic t_late_abort_and_miss();
        logic [2:0] tg [4] = '{3'd2, 3'd6, 3'd0, 3'd4};
        logic [63:0] dv [4] = '{64'hC2, 64'hC6, 64'hC0, 64'hC4};
        logic [255:0] exp;
        start_req(30'h00000400);
        accept();
        abort = 1'b1; miss = 1'b1; maddr = 30'h3FFFFFF8;
        @(negedge clk);
        chk("R8 busy kept", busy, 1);
        chk("R9 addr kept", laddr, 30'h00000400);
        beats(tg, dv, exp);
        abort = 1'b0; miss = 1'b0;
        chk("R8 still writes", lwe, 1);
        chk("R9 line addr", laddr, 30'h00000400);
        chk("R8 data", ldata, exp);
        @(negedge clk);
    endtask

    task automatic t_ratio3();
        logic [2:0] tg [4] = '{3'd4, 3'd2, 3'd6, 3'd0};
        logic [63:0] dv [4] = '{64'h3_4, 64'h3_2, 64'h3_6, 64'h3_0};
        logic [255:0] exp;
        ratio = 3;
        repeat (3) @(negedge clk);
        start_req(30'h15555557);
        while (bus_en) @(negedge clk);
        aack = 1'b1;
        @(negedge clk);
        aack = 1'b0;
        chk("R3 off-edge ack ignored", req, 1);
        accept();
        while (bus_en) @(negedge clk);
        rack = 1'b1; tag = 3'd2; rdata = 64'hBAD;
        @(negedge clk);
        rack = 1'b0;
        beats(tg, dv, exp);
        chk("R5 ratio3 we", lwe, 1);
        chk("R5 ratio3 data", ldata, exp);
        @(negedge clk);
        ratio = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_in_order();
        t_out_of_order();
        t_abort_same();
        t_abort_then_restart();
        t_late_abort_and_miss();
        t_ratio3();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule